// File: doc/BRIEF.md
# Two-Class Rotating-Priority DMA Arbiter

This block chooses which DMA channel of a controller may use the system bus next. The channels form two classes. One class holds the peripheral channels, which move data in either direction between memory and a peripheral. The other class holds the memory-to-memory channels. A static input bit chooses which class goes first. Inside each class, priority rotates: the channel that won last time becomes the lowest-priority channel in its class.

Once a winner is chosen, the block raises one bus request toward an external system-bus arbiter. It drives a one-hot grant to the winning channel. Both stay steady until two things have happened in order: the external arbiter has granted the bus, and after that the granted channel reports that its burst is done. The block then releases both outputs. On the next clock edge it arbitrates again.

Top module: `dma_class_arbiter`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `bus_req` is 0, `per_gnt` is all zeros and `mem_gnt` is all zeros.
- R2: When no request bit has been high since the last release, `bus_req` stays 0 and both grant vectors stay all zeros.
- R3: The concatenation {`mem_gnt`, `per_gnt`} never has more than one bit set. A bit set in it belongs to a channel whose request bit was high at the clock edge that made the decision.
- R4: When `mem_first` is 0 and at least one `per_req` bit is high, the winner is a peripheral channel. A memory-to-memory channel wins only when no peripheral channel requests.
- R5: When `mem_first` is 1 and at least one `mem_req` bit is high, the winner is a memory-to-memory channel. A peripheral channel wins only when no memory-to-memory channel requests.
- R6: Inside a class, after channel k is granted, channel k+1 has the highest priority for that class's next win. The order then runs upward and wraps from the class's last channel back to channel 0.
- R7: After reset, channel 0 of each class has the highest priority within that class.
- R8: A grant and `bus_req` stay unchanged until `bus_gnt` has been seen and then `burst_done` is seen in a later cycle. A `burst_done` pulse before or in the same cycle as `bus_gnt` has no effect. Dropping request bits while a grant is held also has no effect.
- R9: The clock edge that samples the qualifying `burst_done` clears `bus_req` and both grant vectors. The next decision is taken at the following edge. A decision moves only the rotation of the class that won, never the rotation of the other class.
- R10: `bus_req` is 1 exactly when some bit of {`mem_gnt`, `per_gnt`} is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_first | input | 1 | Class priority select: 0 = peripheral class first, 1 = memory-to-memory class first |
| per_req | input | N_PER (10) | Request bits of the peripheral-class channels |
| mem_req | input | N_MEM (2) | Request bits of the memory-to-memory channels |
| bus_gnt | input | 1 | Grant from the external system-bus arbiter |
| burst_done | input | 1 | Pulse from the granted channel when its burst ends |
| bus_req | output | 1 | Registered request to the external system-bus arbiter |
| per_gnt | output | N_PER (10) | Registered one-hot grant to a peripheral channel |
| mem_gnt | output | N_MEM (2) | Registered one-hot grant to a memory-to-memory channel |

## Verification
The stimulus uses full request vectors in both classes to show how each class advances and wraps its own rotation. Sparse vectors, such as peripheral channels 1 and 9 only, separate a rotating pointer from a fixed-priority scan. Requests from both classes arrive under each setting of `mem_first`, and requests from one class arrive alone. Together these separate class priority from a design that serves whichever class requests. Some transactions pulse `burst_done` before `bus_gnt` or drop the request bits while the grant is held. These show that a grant is released only by the ordered grant-then-done handshake. A randomized run then mixes all of these patterns.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Phases of one bus tenure
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,   // free to decide
    ARB_WAIT = 2'd1,   // request raised, waiting for the bus grant
    ARB_XFER = 2'd2    // bus granted, waiting for end of burst
  } arb_state_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dma_arb_rr_pick.sv
// Round-robin picker for one channel class. It holds the index of the
// highest-priority channel and moves it past the winner on adv.
module dma_arb_rr_pick
  import dma_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] pick,
  output logic         any
);

  localparam int IW = idx_width(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr;
  logic [IW-1:0] win_idx;

  always_comb begin
    int idx;
    pick    = '0;
    any     = 1'b0;
    win_idx = '0;
    for (int o = 0; o < N; o++) begin
      idx = int'(ptr) + o;
      if (idx >= N) idx = idx - N;
      if (!any && req[idx]) begin
        any       = 1'b1;
        pick[idx] = 1'b1;
        win_idx   = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (win_idx == LAST) ? '0 : win_idx + IW'(1);
    end
  end

endmodule

// File: rtl/dma_arb_ctrl.sv
// Tenure controller: latches the winner and holds it until the bus grant
// has been seen and then the end of burst is signalled.
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NT = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any,
  input  logic [NT-1:0] win,
  input  logic          bus_gnt,
  input  logic          burst_done,
  output logic [NT-1:0] grant,
  output logic          bus_req,
  output logic          take
);

  arb_state_t state;

  assign take = (state == ARB_IDLE) && any;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ARB_IDLE;
      grant   <= '0;
      bus_req <= 1'b0;
    end else begin
      unique case (state)
        ARB_IDLE: begin
          if (take) begin
            grant   <= win;
            bus_req <= 1'b1;
            state   <= ARB_WAIT;
          end
        end
        ARB_WAIT: begin
          if (bus_gnt) state <= ARB_XFER;
        end
        ARB_XFER: begin
          if (burst_done) begin
            grant   <= '0;
            bus_req <= 1'b0;
            state   <= ARB_IDLE;
          end
        end
        default: begin
          grant   <= '0;
          bus_req <= 1'b0;
          state   <= ARB_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/dma_class_arbiter.sv
module dma_class_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_PER = 10,
  parameter int N_MEM = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mem_first,
  input  logic [N_PER-1:0] per_req,
  input  logic [N_MEM-1:0] mem_req,
  input  logic             bus_gnt,
  input  logic             burst_done,
  output logic             bus_req,
  output logic [N_PER-1:0] per_gnt,
  output logic [N_MEM-1:0] mem_gnt
);

  localparam int NT = N_PER + N_MEM;

  logic [N_PER-1:0] per_pick;
  logic [N_MEM-1:0] mem_pick;
  logic             per_any, mem_any;
  logic             mem_wins, take;
  logic [NT-1:0]    win, grant;

  dma_arb_rr_pick #(.N(N_PER)) u_per_pick (
    .clk (clk), .rst (rst), .req (per_req),
    .adv (take && !mem_wins), .pick (per_pick), .any (per_any)
  );

  dma_arb_rr_pick #(.N(N_MEM)) u_mem_pick (
    .clk (clk), .rst (rst), .req (mem_req),
    .adv (take && mem_wins), .pick (mem_pick), .any (mem_any)
  );

  // Class selection: the preferred class wins whenever it has a request
  assign mem_wins = mem_first ? mem_any : (mem_any && !per_any);
  assign win      = mem_wins ? {mem_pick, {N_PER{1'b0}}}
                             : {{N_MEM{1'b0}}, per_pick};

  dma_arb_ctrl #(.NT(NT)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .any        (per_any || mem_any),
    .win        (win),
    .bus_gnt    (bus_gnt),
    .burst_done (burst_done),
    .grant      (grant),
    .bus_req    (bus_req),
    .take       (take)
  );

  assign per_gnt = grant[N_PER-1:0];
  assign mem_gnt = grant[NT-1:N_PER];

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int N_PER = 10,
  parameter int N_MEM = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_first,
  input logic [N_PER-1:0] per_req,
  input logic [N_MEM-1:0] mem_req,
  input logic             bus_gnt,
  input logic             burst_done,
  input logic             bus_req,
  input logic [N_PER-1:0] per_gnt,
  input logic [N_MEM-1:0] mem_gnt
);

  localparam int NT = N_PER + N_MEM;
  logic [NT-1:0] gv;
  logic [NT-1:0] rv;
  assign gv = {mem_gnt, per_gnt};
  assign rv = {mem_req, per_req};

  p_onehot_grant_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gv));

  p_grant_from_request_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> ((gv & $past(rv)) == gv));

  p_per_first_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && !$past(mem_first) && $past(|per_req)) |-> (|per_gnt));

  p_mem_first_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && $past(mem_first) && $past(|mem_req)) |-> (|mem_gnt));

  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!bus_req && !(|rv)) |=> !bus_req);

  p_hold_until_done_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !burst_done) |=> (bus_req && $stable(gv)));

  p_req_tracks_grant_r10: assert property (@(posedge clk) disable iff (rst)
    bus_req == (|gv));

endmodule

bind dma_class_arbiter dma_arb_chk #(.N_PER(N_PER), .N_MEM(N_MEM)) u_chk (
  .clk (clk), .rst (rst), .mem_first (mem_first), .per_req (per_req),
  .mem_req (mem_req), .bus_gnt (bus_gnt), .burst_done (burst_done),
  .bus_req (bus_req), .per_gnt (per_gnt), .mem_gnt (mem_gnt)
);

// File: tb/test_dma_class_arbiter.sv
module test_dma_class_arbiter;

  localparam int NP = 10;
  localparam int NM = 2;
  localparam int NT = NP + NM;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mem_first = 1'b0;
  logic [NP-1:0] per_req = '0;
  logic [NM-1:0] mem_req = '0;
  logic          bus_gnt = 1'b0;
  logic          burst_done = 1'b0;
  logic          bus_req;
  logic [NP-1:0] per_gnt;
  logic [NM-1:0] mem_gnt;

  int checks = 0;
  int fails  = 0;
  int pp = 0;            // model pointer, peripheral class
  int mp = 0;            // model pointer, memory class
  bit finished = 1'b0;
  bit prev_bus = 1'b0;

  logic [NT-1:0] exp_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  dma_class_arbiter i_dma_class_arbiter (
    .clk (clk), .rst (rst), .mem_first (mem_first), .per_req (per_req),
    .mem_req (mem_req), .bus_gnt (bus_gnt), .burst_done (burst_done),
    .bus_req (bus_req), .per_gnt (per_gnt), .mem_gnt (mem_gnt)
  );

  function automatic logic [NT-1:0] gv();
    return {mem_gnt, per_gnt};
  endfunction

  task automatic chk(input bit ok, input string rq,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  // Requirement model of one decision (R4, R5, R6, R7, R9)
  task automatic model(input logic [NP-1:0] pr, input logic [NM-1:0] mr,
                       input bit mf, output logic [NT-1:0] e);
    bit usemem;
    bit found;
    int idx;
    usemem = mf ? (mr != 0) : ((mr != 0) && (pr == 0));
    e = '0;
    found = 1'b0;
    if (usemem) begin
      for (int o = 0; o < NM; o++) begin
        idx = (mp + o) % NM;
        if (!found && mr[idx]) begin
          found = 1'b1;
          e[NP + idx] = 1'b1;
          mp = (idx + 1) % NM;
        end
      end
    end else if (pr != 0) begin
      for (int o = 0; o < NP; o++) begin
        idx = (pp + o) % NP;
        if (!found && pr[idx]) begin
          found = 1'b1;
          e[idx] = 1'b1;
          pp = (idx + 1) % NP;
        end
      end
    end
  endtask

  // Monitor: pops the expected winner on each new bus request
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(bus_req == (|gv()), "R10", 32'(bus_req), 32'(|gv()));
      if (bus_req && !prev_bus) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", 32'(gv()), 32'h0);
        end else begin
          logic [NT-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(gv() == e, t, 32'(gv()), 32'(e));
        end
      end
      prev_bus = bus_req;
    end
  end

  // Driver: one full tenure
  task automatic txn(input logic [NP-1:0] pr, input logic [NM-1:0] mr,
                     input bit mf, input bit early, input bit drop,
                     input string tag);
    logic [NT-1:0] e;
    @(negedge clk);
    per_req = pr; mem_req = mr; mem_first = mf;
    model(pr, mr, mf, e);
    if (e == '0) begin
      @(negedge clk);
      chk(!bus_req && gv() == '0, "R2", 32'(gv()), 32'h0);
      return;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);                    // decision registered
    if (drop) begin per_req = '0; mem_req = '0; end
    if (early) begin
      burst_done = 1'b1;
      @(negedge clk);
      burst_done = 1'b0;
      chk(bus_req && gv() == e, "R8", 32'(gv()), 32'(e));
    end
    repeat (2) @(negedge clk);
    chk(bus_req && gv() == e, "R8", 32'(gv()), 32'(e));
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    chk(bus_req && gv() == e, "R8", 32'(gv()), 32'(e));
    @(negedge clk);
    burst_done = 1'b1;
    @(negedge clk);
    burst_done = 1'b0;
    per_req = '0; mem_req = '0;
    chk(!bus_req && gv() == '0, "R9", 32'(gv()), 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_req && gv() == '0, "R1", 32'(gv()), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && gv() == '0, "R1", 32'(gv()), 32'h0);
    repeat (4) @(negedge clk);
    chk(!bus_req && gv() == '0, "R2", 32'(gv()), 32'h0);

    txn('1, '1, 1'b0, 1'b0, 1'b0, "R7 R4");        // peripheral ch0
    txn('1, '1, 1'b0, 1'b0, 1'b0, "R6");           // peripheral ch1
    txn(10'h202, '0, 1'b0, 1'b0, 1'b0, "R6");      // ch9 (pointer at 2)
    txn(10'h202, '0, 1'b0, 1'b0, 1'b0, "R6");      // wraps to ch1
    txn('1, '1, 1'b1, 1'b0, 1'b0, "R5 R7");        // memory ch0
    txn('1, '1, 1'b1, 1'b0, 1'b0, "R5 R6");        // memory ch1
    txn('1, '1, 1'b1, 1'b0, 1'b0, "R6");           // memory wraps to ch0
    txn('1, '0, 1'b1, 1'b0, 1'b0, "R5 R9");        // peripheral rotation kept
    txn('0, 2'b10, 1'b0, 1'b0, 1'b0, "R4");        // memory alone wins
    txn(10'h010, '0, 1'b0, 1'b1, 1'b0, "R8");      // early done ignored
    txn(10'h008, 2'b01, 1'b1, 1'b0, 1'b1, "R8");   // dropped requests
    txn('0, '0, 1'b0, 1'b0, 1'b0, "R2");

    for (int i = 0; i < 40; i++) begin
      txn(NP'($urandom), NM'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), "R3 R6");
    end

    per_req = '0; mem_req = '0;
    repeat (5) @(negedge clk);
    chk(!bus_req && gv() == '0, "R2", 32'(gv()), 32'h0);
    chk(exp_q.size() == 0, "R3", 32'(exp_q.size()), 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule